// File: doc/BRIEF.md
# Quad Recirculating Serial Delay Line

The block holds four independent serial shift registers, lanes A to D, each `DEPTH` stages long (64 by default). Every lane has its own serial input, its own shift enable and its own serial output, which is always the last stage. On a clock edge where a lane's enable is high, every bit moves one stage toward the output, and a new bit enters the first stage. Lanes with the enable low keep their contents.

Two recycle selects decide where the new bit comes from. One serves lanes A and B, the other serves lanes C and D. With the select low, the lane takes its external serial input. With it high, the lane takes its own output bit, so the stored word rotates. After `DEPTH` recycled shifts the word is back where it started. The block can store a word and replay it, or act as a delay line. Lanes can be chained by wiring one lane's output to the next lane's input.

Everything runs on one system clock. A synchronous active-high reset clears all stages.

Top module: `quad_recirc_delay`

## Requirements
- R1: A clock edge with `rst` high clears every stage of every lane to 0, so each `ser_out` bit reads 0 afterwards. Recycling a cleared lane keeps it all zeros.
- R2: `ser_out[i]` is the last stage of lane i. A bit that enters lane i on one shift appears on `ser_out[i]` right after the `DEPTH`-th shift of that lane, counting the entry shift as the first.
- R3: A lane whose `shift_en` bit is low at a clock edge keeps every stage unchanged, whatever its serial input and recycle select are doing.
- R4: On a shift with its recycle select high, a lane loads its own pre-shift output bit into the first stage.
- R5: On a shift with its recycle select low, a lane loads its `ser_in` bit into the first stage.
- R6: `recycle[0]` governs lanes A and B (bits 0 and 1). `recycle[1]` governs lanes C and D (bits 2 and 3).
- R7: Bit i of `shift_en` moves lane i only. Lanes A to D are bits 0 to 3 of `shift_en`, `ser_in` and `ser_out`.
- R8: A word loaded over `DEPTH` external shifts, then recycled `DEPTH` times, reads out unchanged: the first bit loaded is the first bit read out.
- R9: The recycle select and serial input are sampled on the same edge as the shift they steer. A select change applies to that very shift.
- R10: With `ser_out` of lane A wired to `ser_in` of lane B and both shifting together, a bit entering A appears at B's output after exactly 2·`DEPTH` shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear of all stages |
| shift_en | input | 4 | Per-lane shift enable, bit 0 = lane A |
| ser_in | input | 4 | Per-lane external serial input |
| recycle | input | 2 | Recycle select, bit 0 for lanes A/B, bit 1 for lanes C/D |
| ser_out | output | 4 | Per-lane serial output (last stage) |

## Verification
The in-lane properties assume that every input is a defined level at each rising edge. They also assume that reset is applied as a synchronous level that holds stage contents at zero. The stimulus only changes inputs on falling edges, so each edge sees settled values.

The bench applies reset at the start and again in mid-run. After each reset, every one-step shift, load and recycle relation starts fresh. The long sweep deliberately changes recycle selects between consecutive shifts, which checks that a mode change lands on the edge where it is sampled.

// File: rtl/qrd_pkg.sv
package qrd_pkg;
    localparam int unsigned LANES_PER_PAIR = 2;

    typedef enum logic {
        FEED_EXT  = 1'b0,
        FEED_LOOP = 1'b1
    } feed_e;
endpackage

// File: rtl/qrd_lane.sv
module qrd_lane
    import qrd_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  logic ser_in,
    input  logic recycle,
    output logic ser_out
);
    localparam int unsigned LAST = DEPTH - 1;

    typedef struct packed {
        logic [DEPTH-1:0] sr;
    } lane_t;

    lane_t st_d, st_q;
    feed_e feed;
    logic  head_bit;

    always_comb begin
        feed     = feed_e'(recycle);
        head_bit = (feed == FEED_LOOP) ? st_q.sr[LAST] : ser_in;
        st_d     = st_q;
        if (rst) begin
            st_d.sr = '0;
        end else if (shift_en) begin
            st_d.sr = {st_q.sr[LAST-1:0], head_bit};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ser_out = st_q.sr[LAST];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (st_q.sr == '0));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(st_q.sr));

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (st_q.sr[LAST:1] == $past(st_q.sr[LAST-1:0])));

    // R4
    loop_feed_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && recycle) |=> (st_q.sr[0] == $past(ser_out)));

    // R5
    ext_feed_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !recycle) |=> (st_q.sr[0] == $past(ser_in)));
endmodule

// File: rtl/qrd_pair.sv
module qrd_pair
    import qrd_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LANES_PER_PAIR-1:0] shift_en,
    input  logic [LANES_PER_PAIR-1:0] ser_in,
    input  logic                      recycle,
    output logic [LANES_PER_PAIR-1:0] ser_out
);
    for (genvar l = 0; l < LANES_PER_PAIR; l++) begin : g_lane
        qrd_lane #(.DEPTH(DEPTH)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .shift_en (shift_en[l]),
            .ser_in   (ser_in[l]),
            .recycle  (recycle),
            .ser_out  (ser_out[l])
        );
    end
endmodule

// File: rtl/quad_recirc_delay.sv
module quad_recirc_delay
    import qrd_pkg::*;
#(
    parameter int unsigned DEPTH   = 64,
    parameter int unsigned N_PAIRS = 2,
    localparam int unsigned LANES  = N_PAIRS * LANES_PER_PAIR
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LANES-1:0]   shift_en,
    input  logic [LANES-1:0]   ser_in,
    input  logic [N_PAIRS-1:0] recycle,
    output logic [LANES-1:0]   ser_out
);
    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        qrd_pair #(.DEPTH(DEPTH)) u_pair (
            .clk      (clk),
            .rst      (rst),
            .shift_en (shift_en[p*LANES_PER_PAIR +: LANES_PER_PAIR]),
            .ser_in   (ser_in[p*LANES_PER_PAIR +: LANES_PER_PAIR]),
            .recycle  (recycle[p]),
            .ser_out  (ser_out[p*LANES_PER_PAIR +: LANES_PER_PAIR])
        );
    end
endmodule

// File: tb/sim_quad_recirc_delay.sv
module sim_quad_recirc_delay;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] shift_en;
    logic [3:0] ser_in;
    logic [1:0] recycle;
    logic [3:0] ser_out;

    logic [DEPTH-1:0] mdl [4];
    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    quad_recirc_delay u0 (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .ser_in   (ser_in),
        .recycle  (recycle),
        .ser_out  (ser_out)
    );

    function automatic logic [3:0] model_out();
        logic [3:0] o;
        for (int i = 0; i < 4; i++) o[i] = mdl[i][DEPTH-1];
        return o;
    endfunction

    task automatic check_bits(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: ser_out=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; shift_en = '0; ser_in = '0; recycle = '0;
        @(posedge clk);
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One clock edge with the given drive; the model follows the requirements.
    task automatic step(input logic [3:0] en, input logic [3:0] d,
                        input logic [1:0] rc, input string req);
        @(negedge clk);
        shift_en = en; ser_in = d; recycle = rc;
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            if (en[i]) begin
                logic nb;
                nb = rc[i/2] ? mdl[i][DEPTH-1] : d[i];
                mdl[i] = {mdl[i][DEPTH-2:0], nb};
            end
        end
        #1;
        check_bits(req, ser_out, model_out());
    endtask

    function automatic logic pat_bit(input int lane, input int j);
        return (((j * (lane + 3)) + lane * 7) % 5) < 2;
    endfunction

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: ser_out=%b expected=finished run", ser_out);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic [3:0]  hold;
        int          hit;
        rst = 1'b1; shift_en = '0; ser_in = '0; recycle = '0;
        do_reset();
        #1;
        // R1: cleared after reset
        check_bits("R1 reset", ser_out, 4'b0000);
        for (int k = 0; k < DEPTH; k++) step(4'hF, 4'hF, 2'b11, "R1 recycle zeros");

        // R2: a single 1 reaches the output on exactly the DEPTH-th shift
        step(4'hF, 4'hF, 2'b00, "R5 load ones");
        for (int k = 1; k < DEPTH; k++) begin
            step(4'hF, 4'h0, 2'b00, "R2 travel");
            if (k == DEPTH - 2) check_bits("R2 not early", ser_out, 4'b0000);
        end
        check_bits("R2 arrival", ser_out, 4'b1111);

        // R3: no enable, toggling inputs and selects, outputs hold
        hold = ser_out;
        for (int k = 0; k < 8; k++) step(4'h0, 4'(k), 2'(k), "R3 hold");
        check_bits("R3 held value", ser_out, hold);

        // R7: independent enables; R6: shared recycle per pair
        for (int k = 0; k < 40; k++) step(4'b0101, 4'hA, 2'b01, "R7 partial enable");
        for (int k = 0; k < 40; k++) step(4'hF, 4'(k * 3), 2'b01, "R6 AB loop CD load");
        for (int k = 0; k < 40; k++) step(4'hF, 4'(k * 5), 2'b10, "R6 AB load CD loop");

        // R8: load, recycle DEPTH times, read out in order
        for (int j = 0; j < DEPTH; j++) begin
            logic [3:0] d;
            for (int i = 0; i < 4; i++) d[i] = pat_bit(i, j);
            step(4'hF, d, 2'b00, "R5 pattern load");
        end
        for (int k = 0; k < DEPTH; k++) step(4'hF, 4'h0, 2'b11, "R4 recirculate");
        for (int j = 0; j < DEPTH; j++) begin
            logic [3:0] e;
            for (int i = 0; i < 4; i++) e[i] = pat_bit(i, j);
            #0;
            check_bits("R8 readout", ser_out, e);
            step(4'hF, 4'h0, 2'b00, "R8 drain");
        end

        // R9: mode flips every shift, long pseudo-random sweep
        lfsr = 16'hACE1;
        for (int k = 0; k < 2000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3:0], lfsr[7:4], lfsr[9:8], "R9 sweep");
        end

        // R1: mid-run reset
        do_reset();
        #1;
        check_bits("R1 mid-run reset", ser_out, 4'b0000);

        // R10: lane A feeds lane B, delay of 2*DEPTH
        hit = -1;
        for (int k = 1; k <= 2 * DEPTH + 4; k++) begin
            logic [3:0] d;
            d = {2'b00, ser_out[0], (k == 1) ? 1'b1 : 1'b0};
            step(4'b0011, d, 2'b00, "R10 cascade");
            if (hit < 0 && ser_out[1]) hit = k;
        end
        checks++;
        if (hit != 2 * DEPTH) begin
            errors++;
            $display("FAIL R10 cascade delay: actual=%0d expected=%0d", hit, 2 * DEPTH);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule